// File: doc/BRIEF.md
# Selectable-Edge Quadrature Step Decoder

This block watches two asynchronous pins, `in_a_i` and `in_b_i`, and turns their transitions into one-cycle step pulses that a downstream position counter can add or subtract. Both pins are first resynchronised into the core clock domain. A transition is found by comparing each synchronised sample with the sample from the cycle before. The block has two modes. In quadrature mode it works out the direction of each step from four things: which pin moved, whether it rose or fell, and the synchronised level of the other pin. In counting mode it treats `in_a_i` as a plain event input and produces only up steps.

The edge-select input picks which transitions count: rising edges only, falling edges only, or both. In quadrature mode this gives one, two or four steps per cycle of the two signals. A fourth select code turns stepping off completely. When both pins move within the same sampled cycle in quadrature mode, the direction cannot be known. The block then reports an error pulse and produces no step. The enable input gates every output.

Top module: `qdec_step_top`

## Requirements
- R1: A pin transition driven just after a clock edge produces its output pulse after the third rising clock edge, and not before. This latency comes from two synchroniser flops and one output register.
- R2: With `quad_i`=0, each active edge of `in_a_i` produces one up pulse. `in_b_i` has no effect, and `down_o` and `err_o` stay low.
- R3: In quadrature mode, a rising `in_a_i` steps down when `in_b_i` is high and steps up when `in_b_i` is low.
- R4: In quadrature mode, a rising `in_b_i` steps up when `in_a_i` is high and steps down when `in_a_i` is low.
- R5: In quadrature mode, a falling `in_a_i` steps up when `in_b_i` is high and steps down when `in_b_i` is low.
- R6: In quadrature mode, a falling `in_b_i` steps down when `in_a_i` is high and steps up when `in_a_i` is low.
- R7: The `edge_sel_i` codes are 0 for rising edges only, 1 for falling edges only and 2 for both edges. Edges of a kind that is not selected produce no pulse.
- R8: With `edge_sel_i`=3, no up, down or error pulse is produced.
- R9: In quadrature mode, when both pins change in the same sampled cycle, no step is produced and `err_o` pulses for one cycle.
- R10: `up_o` and `down_o` are never high together, and each transition gives a pulse exactly one cycle long.
- R11: In the cycle after `en_i` is low, all outputs are low. A transition that happens while the block is disabled is dropped and does not appear after the block is enabled again.
- R12: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Decoder enable |
| quad_i | input | 1 | 1 selects quadrature mode, 0 selects single-input counting |
| edge_sel_i | input | 2 | Active edge: 0 rising, 1 falling, 2 both, 3 none |
| in_a_i | input | 1 | First external input, asynchronous |
| in_b_i | input | 1 | Second external input, asynchronous |
| up_o | output | 1 | One-cycle up step pulse |
| down_o | output | 1 | One-cycle down step pulse |
| err_o | output | 1 | One-cycle pulse when both inputs change together |

## Verification
The bench takes the pins through full cycles under every edge code and in both directions. This catches a swapped table entry, which would show up as a reversed pulse on one quarter of the cycle. A mask decode that is off by one would count edges the selected code should skip. The bench also moves both pins in one cycle: a design that skipped the conflict check would emit a step in an arbitrary direction, while one that applied the check in counting mode would wrongly drop a real up step. Other tests toggle a pin while the block is disabled and set the select to no action. A design that does not update its edge history during these periods would release a stale pulse later. Each check samples at the exact third edge, so an extra or a missing pipeline stage is caught.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    SEL_RISE = 2'd0,
    SEL_FALL = 2'd1,
    SEL_BOTH = 2'd2,
    SEL_NONE = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic err;
  } step_t;

  localparam int unsigned NUM_PINS = 2;
  localparam int unsigned PIN_A    = 0;
  localparam int unsigned PIN_B    = 1;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_edge.sv
module qdec_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  // history always tracks, even when disabled, so no stale edges later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    assign rise_o[i] =  cur_i[i] & ~prev_q[i];
    assign fall_o[i] = ~cur_i[i] &  prev_q[i];
  end
endmodule

// File: rtl/qdec_dir.sv
module qdec_dir
  import qdec_pkg::*;
(
  input  logic                quad_i,
  input  logic [1:0]          edge_sel_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] rise_i,
  input  logic [NUM_PINS-1:0] fall_i,
  output step_t               step_o
);
  logic rise_en, fall_en;
  logic [NUM_PINS-1:0] act, chg;

  assign rise_en = (edge_sel_i == SEL_RISE) || (edge_sel_i == SEL_BOTH);
  assign fall_en = (edge_sel_i == SEL_FALL) || (edge_sel_i == SEL_BOTH);
  assign act     = (rise_i & {NUM_PINS{rise_en}}) | (fall_i & {NUM_PINS{fall_en}});
  assign chg     = rise_i | fall_i;

  always_comb begin
    step_o = '0;
    if (!quad_i) begin
      step_o.up = act[PIN_A];
    end else if (chg[PIN_A] && chg[PIN_B]) begin
      step_o.err = (edge_sel_i != SEL_NONE);
    end else if (act[PIN_A]) begin
      unique case ({rise_i[PIN_A], lvl_i[PIN_B]})
        2'b11:   step_o.dn = 1'b1;
        2'b10:   step_o.up = 1'b1;
        2'b01:   step_o.up = 1'b1;
        default: step_o.dn = 1'b1;
      endcase
    end else if (act[PIN_B]) begin
      unique case ({rise_i[PIN_B], lvl_i[PIN_A]})
        2'b11:   step_o.up = 1'b1;
        2'b10:   step_o.dn = 1'b1;
        2'b01:   step_o.dn = 1'b1;
        default: step_o.up = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/qdec_step_top.sv
module qdec_step_top
  import qdec_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       quad_i,
  input  logic [1:0] edge_sel_i,
  input  logic       in_a_i,
  input  logic       in_b_i,
  output logic       up_o,
  output logic       down_o,
  output logic       err_o
);
  logic [NUM_PINS-1:0] pins_s, rise, fall;
  step_t step_d, step_q;

  qdec_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({in_b_i, in_a_i}),
    .q_o   (pins_s)
  );

  qdec_edge #(.WIDTH(NUM_PINS)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cur_i (pins_s),
    .rise_o(rise),
    .fall_o(fall)
  );

  qdec_dir u_dir (
    .quad_i    (quad_i),
    .edge_sel_i(edge_sel_i),
    .lvl_i     (pins_s),
    .rise_i    (rise),
    .fall_i    (fall),
    .step_o    (step_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   step_q <= '0;
    else if (en_i) step_q <= step_d;
    else           step_q <= '0;
  end

  assign up_o   = step_q.up;
  assign down_o = step_q.dn;
  assign err_o  = step_q.err;

  // R10
  no_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && down_o));

  // R11
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!up_o && !down_o && !err_o));

  // R8
  sel_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == SEL_NONE) |=> (!up_o && !down_o && !err_o));

  // R9
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!up_o && !down_o));

  // R2
  cnt_up_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !quad_i |=> (!down_o && !err_o));
endmodule

// File: tb/qdec_step_top_bench.sv
`timescale 1ns/1ps
module qdec_step_top_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, quad = 1'b1;
  logic [1:0] sel = 2'd0;
  logic a = 1'b0, b = 1'b0;
  logic up, dn, err;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qdec_step_top u_qdec_step_top (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .quad_i(quad), .edge_sel_i(sel),
    .in_a_i(a), .in_b_i(b), .up_o(up), .down_o(dn), .err_o(err)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {up,dn,err} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive pins after an edge, verify quiet at edge 2, pulse at edge 3, quiet at edge 4
  task automatic step_chk(input logic na, input logic nb, input logic [2:0] exp, input string req);
    @(negedge clk); a = na; b = nb;
    repeat (2) @(posedge clk); #1;
    chk({req, " R1 early"}, {up, dn, err}, 3'b000);
    @(posedge clk); #1;
    chk(req, {up, dn, err}, exp);
    @(posedge clk); #1;
    chk({req, " R10 width"}, {up, dn, err}, 3'b000);
  endtask

  task automatic set_mode(input logic q, input logic [1:0] s);
    @(negedge clk); quad = q; sel = s;
  endtask

  task automatic t_rise_only();
    set_mode(1'b1, 2'd0);
    step_chk(1'b1, 1'b0, 3'b100, "R3 rise a, b low");
    step_chk(1'b1, 1'b1, 3'b100, "R4 rise b, a high");
    step_chk(1'b0, 1'b1, 3'b000, "R7 fall a masked");
    step_chk(1'b0, 1'b0, 3'b000, "R7 fall b masked");
    step_chk(1'b0, 1'b1, 3'b010, "R4 rise b, a low");
    step_chk(1'b1, 1'b1, 3'b010, "R3 rise a, b high");
  endtask

  task automatic t_fall_only();
    set_mode(1'b1, 2'd1);
    step_chk(1'b0, 1'b1, 3'b100, "R5 fall a, b high");
    step_chk(1'b0, 1'b0, 3'b100, "R6 fall b, a low");
    step_chk(1'b0, 1'b1, 3'b000, "R7 rise b masked");
    step_chk(1'b1, 1'b1, 3'b000, "R7 rise a masked");
    step_chk(1'b1, 1'b0, 3'b010, "R6 fall b, a high");
    step_chk(1'b0, 1'b0, 3'b010, "R5 fall a, b low");
  endtask

  task automatic t_both();
    set_mode(1'b1, 2'd2);
    step_chk(1'b1, 1'b0, 3'b100, "R7 x4 fwd 1");
    step_chk(1'b1, 1'b1, 3'b100, "R7 x4 fwd 2");
    step_chk(1'b0, 1'b1, 3'b100, "R7 x4 fwd 3");
    step_chk(1'b0, 1'b0, 3'b100, "R7 x4 fwd 4");
    step_chk(1'b0, 1'b1, 3'b010, "R7 x4 rev 1");
    step_chk(1'b1, 1'b1, 3'b010, "R7 x4 rev 2");
    step_chk(1'b1, 1'b0, 3'b010, "R7 x4 rev 3");
    step_chk(1'b0, 1'b0, 3'b010, "R7 x4 rev 4");
  endtask

  task automatic t_none_and_conflict();
    set_mode(1'b1, 2'd3);
    step_chk(1'b1, 1'b0, 3'b000, "R8 none a");
    step_chk(1'b1, 1'b1, 3'b000, "R8 none b");
    set_mode(1'b1, 2'd2);
    step_chk(1'b0, 1'b0, 3'b001, "R9 both pins move");
  endtask

  task automatic t_counter();
    set_mode(1'b0, 2'd0);
    step_chk(1'b1, 1'b0, 3'b100, "R2 rise a counts");
    step_chk(1'b1, 1'b1, 3'b000, "R2 b ignored");
    step_chk(1'b0, 1'b1, 3'b000, "R2 fall a masked");
    set_mode(1'b0, 2'd1);
    step_chk(1'b1, 1'b1, 3'b000, "R2 rise a masked");
    step_chk(1'b0, 1'b1, 3'b100, "R2 fall a counts");
    set_mode(1'b0, 2'd2);
    step_chk(1'b1, 1'b1, 3'b100, "R2 both rise a");
    step_chk(1'b1, 1'b0, 3'b000, "R2 b fall ignored");
    step_chk(1'b0, 1'b1, 3'b100, "R2 joint move still counts");
  endtask

  task automatic t_enable();
    set_mode(1'b1, 2'd2);
    @(negedge clk); en = 1'b0;
    step_chk(1'b1, 1'b1, 3'b000, "R11 disabled edge");
    @(negedge clk); en = 1'b1;
    repeat (4) begin
      @(posedge clk); #1;
      chk("R11 no stale pulse", {up, dn, err}, 3'b000);
    end
    step_chk(1'b1, 1'b0, 3'b010, "R11 resumes");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset", {up, dn, err}, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk("R12 after reset", {up, dn, err}, 3'b000);
    t_rise_only();
    t_fall_only();
    t_both();
    t_none_and_conflict();
    t_counter();
    t_enable();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule